// File: doc/BRIEF.md
# Interrupt Level Masking Filter

This block sits between a processor's external interrupt request lines and its trap entry logic. Each cycle it looks at the pending request levels, picks the highest one, and compares it against the current processor interrupt level and the trap enable bit. When the request passes the filter, the block issues a one-cycle take strobe. The strobe carries the accepted level and the trap type that the trap entry logic will dispatch on.

Level 0 means that nothing is pending. The top level is non-maskable and passes even when the processor interrupt level is at its maximum. While traps are disabled, every asynchronous request is dropped, whatever its level. The decision is registered, so the trap entry logic sees a clean strobe one clock after the inputs. The filter also leaves an idle cycle after each strobe. In that cycle the trap entry logic clears trap enable before a still-asserted request could be taken a second time.

Top module: `irq_level_filter`

## Requirements
- R1: After a clock edge with `rst_n` low, `take_o` is 0, `take_level_o` is 0 and `take_tt_o` is 0.
- R2: When several request lines are pending, the accepted level is the highest numbered one. Bit i-1 of `irq_req_i` is a request at level i.
- R3: A request at a level from 1 to 14 that is less than or equal to `pil_i` is not taken.
- R4: A request at level 15 is taken for every value of `pil_i`, including 15, provided `trap_en_i` is 1.
- R5: While `trap_en_i` is 0, no request is taken, at any level.
- R6: With no request line asserted (level 0), no request is taken.
- R7: While `take_o` is 1, `take_tt_o` equals 0x10 plus `take_level_o`. While `take_o` is 0, `take_level_o` and `take_tt_o` are both 0.
- R8: The outputs reflect the inputs sampled at the previous rising clock edge. A change of the inputs does not reach the outputs before that edge.
- R9: `take_o` is never 1 in two consecutive cycles. The cycle after a take is always idle, even when the request stays asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_req_i | input | 15 | Request lines; bit i-1 is level i |
| pil_i | input | 4 | Current processor interrupt level |
| trap_en_i | input | 1 | Trap enable; 0 drops all requests |
| take_o | output | 1 | One-cycle strobe: take an interrupt |
| take_level_o | output | 4 | Level of the accepted request |
| take_tt_o | output | 8 | Trap type of the accepted request |

## Verification
The bench builds the block with its default sixteen levels and a trap type base of 0x10. This small configuration allows a full sweep. It covers every highest pending level, every processor interrupt level and both trap enable values, each with several patterns of lower-priority lines. Every mask boundary is therefore reached, including the non-maskable level at the maximum processor interrupt level. Separate sequences hold a request asserted over several cycles to check the forced idle cycle, and sample just before the clock edge to check the registered latency.

// File: rtl/irq_filter_pkg.sv
// Package: shared defaults for the interrupt level filter.
// Assumes level 0 encodes "no request" and the top level is non-maskable.
package irq_filter_pkg;
    localparam int DEF_NUM_LEVELS = 16;
    localparam int DEF_TT_W       = 8;
    localparam logic [7:0] DEF_TT_BASE = 8'h10;
endpackage

// File: rtl/irq_prio_enc.sv
// Module: picks the highest numbered asserted request line.
// Assumes bit i-1 of req_i is level i; output 0 means nothing pending.
module irq_prio_enc #(
    parameter int NUM_LEVELS = 16,
    parameter int LVL_W      = $clog2(NUM_LEVELS)
) (
    input  logic [NUM_LEVELS-2:0] req_i,
    output logic [LVL_W-1:0]      level_o
);
    localparam int TOP = NUM_LEVELS - 1;

    logic [TOP:1] win;

    // Per-level winner: asserted and no higher line asserted.
    for (genvar i = 1; i <= TOP; i++) begin : g_win
        if (i == TOP) begin : g_top
            assign win[i] = req_i[i-1];
        end else begin : g_low
            assign win[i] = req_i[i-1] & ~(|req_i[TOP-1:i]);
        end
    end

    // Encode the single winning level into a number.
    always_comb begin
        level_o = '0;
        for (int i = 1; i <= TOP; i++) begin
            if (win[i]) level_o = LVL_W'(i);
        end
    end
endmodule

// File: rtl/irq_mask_gate.sv
// Module: decides whether the selected level passes the mask and enable.
// Assumes the top level bypasses the mask and level 0 means no request.
module irq_mask_gate #(
    parameter int NUM_LEVELS = 16,
    parameter int LVL_W      = $clog2(NUM_LEVELS),
    parameter int TT_W       = 8,
    parameter logic [TT_W-1:0] TT_BASE = 8'h10
) (
    input  logic [LVL_W-1:0] level_i,
    input  logic [LVL_W-1:0] pil_i,
    input  logic             trap_en_i,
    output logic             accept_o,
    output logic [TT_W-1:0]  tt_o
);
    localparam logic [LVL_W-1:0] NMI_LEVEL = LVL_W'(NUM_LEVELS - 1);

    // Accept only with traps enabled, a real level, and above mask or NMI.
    always_comb begin
        accept_o = trap_en_i && (level_i != '0) &&
                   ((level_i == NMI_LEVEL) || (level_i > pil_i));
    end

    // Trap type is the base plus the level number.
    always_comb begin
        tt_o = TT_BASE + TT_W'(level_i);
    end
endmodule

// File: rtl/irq_level_filter.sv
// Module: top of the interrupt level filter; registers the take decision.
// Assumes the trap entry logic clears trap enable within one idle cycle of a take.
module irq_level_filter
    import irq_filter_pkg::*;
#(
    parameter int NUM_LEVELS = DEF_NUM_LEVELS,
    parameter int LVL_W      = $clog2(NUM_LEVELS),
    parameter int TT_W       = DEF_TT_W,
    parameter logic [TT_W-1:0] TT_BASE = DEF_TT_BASE
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_LEVELS-2:0] irq_req_i,
    input  logic [LVL_W-1:0]      pil_i,
    input  logic                  trap_en_i,
    output logic                  take_o,
    output logic [LVL_W-1:0]      take_level_o,
    output logic [TT_W-1:0]       take_tt_o
);
    localparam logic [LVL_W-1:0] NMI_LEVEL = LVL_W'(NUM_LEVELS - 1);

    logic [LVL_W-1:0] sel_level;
    logic             accept;
    logic [TT_W-1:0]  sel_tt;
    logic             fire;

    irq_prio_enc #(.NUM_LEVELS(NUM_LEVELS), .LVL_W(LVL_W)) u_enc (
        .req_i   (irq_req_i),
        .level_o (sel_level)
    );

    irq_mask_gate #(.NUM_LEVELS(NUM_LEVELS), .LVL_W(LVL_W),
                    .TT_W(TT_W), .TT_BASE(TT_BASE)) u_gate (
        .level_i   (sel_level),
        .pil_i     (pil_i),
        .trap_en_i (trap_en_i),
        .accept_o  (accept),
        .tt_o      (sel_tt)
    );

    // Fire only when accepted and the previous cycle was not a take.
    always_comb fire = accept && !take_o;

    // Output register: one-cycle strobe with level and trap type.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            take_o       <= 1'b0;
            take_level_o <= '0;
            take_tt_o    <= '0;
        end else begin
            take_o       <= fire;
            take_level_o <= fire ? sel_level : '0;
            take_tt_o    <= fire ? sel_tt : '0;
        end
    end

    assert_no_back_to_back_R9: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |=> !take_o);

    assert_disabled_drops_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !trap_en_i |=> !take_o);

    assert_masked_drops_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_level != NMI_LEVEL && sel_level <= pil_i) |=> !take_o);

    assert_nmi_taken_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_en_i && irq_req_i[NUM_LEVELS-2] && !take_o)
        |=> (take_o && take_level_o == NMI_LEVEL));

    assert_tt_matches_R7: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> (take_tt_o == TT_BASE + TT_W'(take_level_o)));

    assert_idle_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !take_o |-> (take_level_o == '0 && take_tt_o == '0));
endmodule

// File: tb/irq_level_filter_bench.sv
`timescale 1ns/1ps
module irq_level_filter_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [14:0] req = '0;
    logic [3:0]  pil = '0;
    logic        et = 1'b0;
    logic        take;
    logic [3:0]  lvl;
    logic [7:0]  tt;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    irq_level_filter u_irq_level_filter (
        .clk(clk), .rst_n(rst_n), .irq_req_i(req), .pil_i(pil),
        .trap_en_i(et), .take_o(take), .take_level_o(lvl), .take_tt_o(tt)
    );

    function automatic int top_of(logic [14:0] r);
        int h = 0;
        for (int i = 1; i <= 15; i++) if (r[i-1]) h = i;
        return h;
    endfunction

    task automatic check(string rq, logic t_e, int l_e, int tt_e);
        checks++;
        if (take !== t_e || lvl !== 4'(l_e) || tt !== 8'(tt_e)) begin
            errors++;
            $display("FAIL %s: got take=%0b lvl=%0d tt=%0h exp take=%0b lvl=%0d tt=%0h",
                     rq, take, lvl, tt, t_e, l_e, tt_e);
        end
    endtask

    // Apply one pattern, sample after the edge, then an idle cycle.
    task automatic run_case(logic [14:0] r, int p, logic e);
        int h;
        logic acc;
        @(negedge clk);
        req = r; pil = 4'(p); et = e;
        h = top_of(r);
        acc = e && h != 0 && (h == 15 || h > p);
        @(posedge clk); #1;
        if (!e)            check("R5", 1'b0, 0, 0);
        else if (h == 0)   check("R6", 1'b0, 0, 0);
        else if (h == 15)  check("R4", 1'b1, 15, 16 + 15);
        else if (!acc)     check("R3", 1'b0, 0, 0);
        else               check("R2/R7", 1'b1, h, 16 + h);
        @(negedge clk);
        req = '0;
        @(posedge clk); #1;
    endtask

    initial begin
        #200000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: got hung exp finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        req = '1; et = 1'b1;
        repeat (2) @(posedge clk);
        #1 check("R1", 1'b0, 0, 0);
        @(negedge clk); rst_n = 1'b1; req = '0;
        @(posedge clk); #1;

        // Near-exhaustive sweep: highest level x pil x enable x lower pattern.
        for (int h = 0; h <= 15; h++) begin
            for (int k = 0; k < 3; k++) begin
                logic [14:0] r;
                logic [14:0] below;
                below = (h > 1) ? ((15'(1) << (h - 1)) - 15'(1)) : '0;
                r = (h > 0) ? (15'(1) << (h - 1)) : '0;
                if (k == 1) r = r | below;
                if (k == 2) r = r | (below & 15'h5555);
                for (int p = 0; p <= 15; p++)
                    for (int e = 0; e <= 1; e++)
                        run_case(r, p, 1'(e));
            end
        end

        // R9: held request gives take, idle, take, idle.
        @(negedge clk); req = 15'h0100; pil = 4'd2; et = 1'b1;
        for (int c = 0; c < 4; c++) begin
            @(posedge clk); #1;
            if (c % 2 == 0) check("R9", 1'b1, 9, 16 + 9);
            else            check("R9", 1'b0, 0, 0);
        end
        @(negedge clk); req = '0;
        repeat (2) @(posedge clk);

        // R8: no change visible before the edge, then visible after it.
        @(negedge clk); req = 15'h0010; pil = 4'd0; et = 1'b1;
        #1 check("R8", 1'b0, 0, 0);
        @(posedge clk); #1 check("R8", 1'b1, 5, 16 + 5);
        @(negedge clk); req = '0;
        @(posedge clk); #1 check("R8", 1'b0, 0, 0);

        // R1: reset clears a pending strobe.
        @(negedge clk); req = 15'h4000; rst_n = 1'b0;
        @(posedge clk); #1 check("R1", 1'b0, 0, 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule